// File: doc/BRIEF.md
# Round-Robin Interleaved Iterative Datapath

This block runs a fixed multi-round update on four independent data words at once. Each round of the update is built once in hardware, as a ring of four pipeline stages: add the word's outer-loop index, subtract the round number, keep the low four bits, and multiply by a constant. All four words of a batch circulate through the ring together, one stage apart. Every stage therefore works on some word in every cycle, and a new round starts each cycle, even though one word's rounds depend on each other.

A batch enters as four data/index pairs over a valid/ready handshake. The round count is sampled when the fourth pair is accepted. The words are fed into the ring on four consecutive cycles. Each word carries its index and its current round number with it through the stages, so no stage needs to select among per-word values. When a word finishes its last round, it leaves the ring. The four results come out on consecutive cycles in the order the words were accepted, followed by a one-cycle done pulse. After that the block accepts the next batch.

Top module: `ilv_round_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle with all ring, buffer and round registers cleared. After that edge `in_ready` is 1 and both `out_valid` and `done` are 0.
- R2: Each result equals the word's data after N rounds of `a = ((((a + idx) - j) & 15) * 3)`, for j = 0 to N-1, with every intermediate value truncated to 16 bits.
- R3: `in_ready` is 0 from the edge that accepts the fourth word of a batch until the edge after the done pulse. Words offered while it is 0 are not taken and do not alter any result.
- R4: The four results appear on four consecutive cycles with `out_valid` high, in acceptance order. `done` is high for exactly the next cycle, and `out_valid` is low in that cycle.
- R5: The first result is visible in the cycle that begins 4·N clock edges after the edge that accepted the fourth word. This corresponds to an initiation interval of one round per cycle.
- R6: A word's result depends only on its own data, its own index and N. Changing another word of the batch leaves it unchanged.
- R7: Idle cycles between accepted words of a batch change neither the results nor the latency counted from the fourth acceptance.
- R8: The round count is sampled on the handshake of the fourth word. Changes on `rounds` after that handshake have no effect on the batch.
- R9: `rounds` values from 1 to 255 run that many rounds. A value of 0 runs one round.
- R10: A reset during processing aborts the batch. No result and no done pulse follow, and the next batch runs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Offered data/index pair is valid |
| in_ready | output | 1 | Block can accept a pair (idle or loading) |
| in_data | input | 16 | Initial loop value of the offered word |
| in_idx | input | 16 | Outer-loop index of the offered word |
| rounds | input | 8 | Number of rounds, sampled with the fourth word |
| out_valid | output | 1 | A finished result is on `out_data` |
| out_data | output | 16 | Result word, in acceptance order |
| done | output | 1 | One-cycle pulse after the last result of a batch |

## Verification
The hardest condition to create from the ports is one where a word's feedback value could be misaligned with its own index and round number. That would happen if something other than a perfectly regular load sequence disturbed the ring. The stimulus produces such conditions by leaving gaps between accepted words, by offering words and changing `rounds` while the ring is busy, and by resetting in the middle of a batch. The checks compare every result with a model computed in the bench, and the cycle count to the first result, against 4·N. Two batches that differ in only one word show that no state crosses between neighbouring words.

// File: rtl/ilv_pkg.sv
// Package: shared constants and controller state type for the interleaved
// round engine. The stage count is fixed by the four round operators.
package ilv_pkg;

    // Number of ring stages, and therefore of words in flight per batch.
    localparam int ILV_STAGES = 4;

    // Controller phases of one batch.
    typedef enum logic [1:0] {
        CTL_LOAD = 2'd0,
        CTL_FEED = 2'd1,
        CTL_RUN  = 2'd2,
        CTL_DONE = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/ilv_stage.sv
// Module: one register stage of the round ring. The OP parameter selects
// which round operator this stage applies (0 add index, 1 subtract round,
// 2 mask, 3 multiply). The index and round number ride along unchanged so
// the next stage always sees the values of the word it holds.
// Assumes: RW <= W, and the multiply result is truncated to W bits.
module ilv_stage #(
    parameter int W    = 16,
    parameter int RW   = 8,
    parameter int OP   = 0,
    parameter int MASK = 15,
    parameter int K    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_ix,
    input  logic [RW-1:0] in_j,
    output logic          out_v,
    output logic [W-1:0]  out_a,
    output logic [W-1:0]  out_ix,
    output logic [RW-1:0] out_j
);

    localparam logic [W-1:0] MASK_W = W'(MASK);
    localparam logic [W-1:0] K_W    = W'(K);

    logic [W-1:0] op_res;

    // Operator chosen by the stage position.
    generate
        if (OP == 0) begin : g_add
            assign op_res = in_a + in_ix;
        end else if (OP == 1) begin : g_sub
            assign op_res = in_a - W'(in_j);
        end else if (OP == 2) begin : g_mask
            assign op_res = in_a & MASK_W;
        end else begin : g_mul
            assign op_res = in_a * K_W;
        end
    endgenerate

    // Stage register: operator result plus the word's travelling context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v  <= 1'b0;
            out_a  <= '0;
            out_ix <= '0;
            out_j  <= '0;
        end else begin
            out_v  <= in_v;
            out_a  <= op_res;
            out_ix <= in_ix;
            out_j  <= in_j;
        end
    end

endmodule

// File: rtl/ilv_load_buf.sv
// Module: shift chain that collects the words of a batch. A shift moves
// every entry one place toward the head and writes the new word at the tail.
// After DEPTH pushes the first accepted word sits at the head, and pops
// (shifts with don't-care input) hand the words out in acceptance order.
// Assumes: pushes and pops never happen in the same cycle.
module ilv_load_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_ix,
    output logic [W-1:0] head_a,
    output logic [W-1:0] head_ix
);

    logic [W-1:0] buf_a  [DEPTH];
    logic [W-1:0] buf_ix [DEPTH];

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            if (e == DEPTH - 1) begin : g_tail
                // Tail entry: takes the incoming word on each shift.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        buf_a[e]  <= '0;
                        buf_ix[e] <= '0;
                    end else if (shift) begin
                        buf_a[e]  <= in_a;
                        buf_ix[e] <= in_ix;
                    end
                end
            end else begin : g_body
                // Inner entry: takes its neighbour toward the tail.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        buf_a[e]  <= '0;
                        buf_ix[e] <= '0;
                    end else if (shift) begin
                        buf_a[e]  <= buf_a[e+1];
                        buf_ix[e] <= buf_ix[e+1];
                    end
                end
            end
        end
    endgenerate

    assign head_a  = buf_a[0];
    assign head_ix = buf_ix[0];

endmodule

// File: rtl/ilv_ctrl.sv
// Module: batch controller. It accepts DS words, captures the last round
// number with the final word, feeds the words into the ring on DS
// consecutive cycles, retires words whose round number reaches the last
// round, and pulses done once DS words have retired.
// Assumes: the ring is empty whenever the controller is in LOAD or FEED.
module ilv_ctrl #(
    parameter int DS = 4,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [RW-1:0] rounds,
    input  logic          tail_v,
    input  logic [RW-1:0] tail_j,
    output logic          in_ready,
    output logic          push,
    output logic          feed,
    output logic          retire,
    output logic          out_valid,
    output logic          done
);

    import ilv_pkg::*;

    localparam int CW = (DS > 1) ? $clog2(DS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DS - 1);

    ctl_state_e    st;
    logic [CW-1:0] cnt;
    logic [RW-1:0] round_last;

    // Phase decode for the datapath.
    always_comb begin
        in_ready  = (st == CTL_LOAD);
        push      = in_ready && in_valid;
        feed      = (st == CTL_FEED);
        retire    = tail_v && (tail_j == round_last);
        out_valid = (st == CTL_RUN) && retire;
        done      = (st == CTL_DONE);
    end

    // Phase sequencing, word counting and round-limit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= CTL_LOAD;
            cnt        <= '0;
            round_last <= '0;
        end else begin
            unique case (st)
                CTL_LOAD: if (push) begin
                    if (cnt == CNT_LAST) begin
                        st         <= CTL_FEED;
                        cnt        <= '0;
                        round_last <= (rounds == '0) ? '0 : rounds - 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CTL_FEED: begin
                    if (cnt == CNT_LAST) begin
                        st  <= CTL_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CTL_RUN: if (out_valid) begin
                    if (cnt == CNT_LAST) begin
                        st  <= CTL_DONE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= CTL_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/ilv_round_engine.sv
// Module: top of the interleaved round engine. Four operator stages form
// a ring. The ring input is the load buffer head during the feed phase and
// the ring's own tail (round number plus one) otherwise. A word whose tail
// round equals the last round is presented on out_data and not fed back.
// Assumes: the stage count equals the batch size (both ILV_STAGES).
module ilv_round_engine #(
    parameter int W    = 16,
    parameter int RW   = 8,
    parameter int K    = 3,
    parameter int MASK = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    input  logic [W-1:0]  in_idx,
    input  logic [RW-1:0] rounds,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          done
);

    localparam int DS = ilv_pkg::ILV_STAGES;

    logic          push, feed, retire;
    logic [W-1:0]  head_a, head_ix;
    logic          sv  [DS];
    logic [W-1:0]  sa  [DS];
    logic [W-1:0]  six [DS];
    logic [RW-1:0] sj  [DS];
    logic          r_v;
    logic [W-1:0]  r_a, r_ix;
    logic [RW-1:0] r_j;

    ilv_ctrl #(.DS(DS), .RW(RW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .rounds   (rounds),
        .tail_v   (sv[DS-1]),
        .tail_j   (sj[DS-1]),
        .in_ready (in_ready),
        .push     (push),
        .feed     (feed),
        .retire   (retire),
        .out_valid(out_valid),
        .done     (done)
    );

    ilv_load_buf #(.W(W), .DEPTH(DS)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (push || feed),
        .in_a   (in_data),
        .in_ix  (in_idx),
        .head_a (head_a),
        .head_ix(head_ix)
    );

    // Ring entry: new word during feed, otherwise the recirculated tail.
    always_comb begin
        if (feed) begin
            r_v  = 1'b1;
            r_a  = head_a;
            r_ix = head_ix;
            r_j  = '0;
        end else begin
            r_v  = sv[DS-1] && !retire;
            r_a  = sa[DS-1];
            r_ix = six[DS-1];
            r_j  = sj[DS-1] + 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < DS; g++) begin : g_stg
            if (g == 0) begin : g_head
                ilv_stage #(.W(W), .RW(RW), .OP(g), .MASK(MASK), .K(K)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .in_v(r_v), .in_a(r_a), .in_ix(r_ix), .in_j(r_j),
                    .out_v(sv[g]), .out_a(sa[g]), .out_ix(six[g]), .out_j(sj[g])
                );
            end else begin : g_chain
                ilv_stage #(.W(W), .RW(RW), .OP(g), .MASK(MASK), .K(K)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .in_v(sv[g-1]), .in_a(sa[g-1]), .in_ix(six[g-1]), .in_j(sj[g-1]),
                    .out_v(sv[g]), .out_a(sa[g]), .out_ix(six[g]), .out_j(sj[g])
                );
            end
        end
    endgenerate

    assign out_data = sa[DS-1];

endmodule

// File: rtl/ilv_round_engine_chk.sv
// Module: protocol checker for the round engine, bound to the top. It
// watches the handshake, the result burst and the done pulse.
// Assumes: DS matches the engine's batch size.
module ilv_round_engine_chk #(
    parameter int DS = ilv_pkg::ILV_STAGES
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic out_valid,
    input logic done
);

    logic [7:0] seen;

    // Count results issued since the last done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         seen <= '0;
        else if (done)      seen <= '0;
        else if (out_valid) seen <= seen + 1'b1;
    end

    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid && !done));

    p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || done) |-> !in_ready);

    p_ready_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);

    p_burst_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |=> out_valid);

    p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid) && !out_valid && seen == 8'(DS)));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen < 8'(DS)));

endmodule

bind ilv_round_engine ilv_round_engine_chk #(.DS(ilv_pkg::ILV_STAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .done     (done)
);

// File: tb/tb_ilv_round_engine.sv
module tb_ilv_round_engine;

    localparam int W  = 16;
    localparam int RW = 8;
    localparam int K  = 3;
    localparam int MASK = 15;
    localparam int DS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic [W-1:0]  in_idx = '0;
    logic [RW-1:0] rounds = '0;
    logic          out_valid;
    logic [W-1:0]  out_data;
    logic          done;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] bd [DS];
    logic [W-1:0] bi [DS];
    logic [W-1:0] res [DS];

    always #4 clk = ~clk;

    ilv_round_engine #(.W(W), .RW(RW), .K(K), .MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_idx(in_idx), .rounds(rounds),
        .out_valid(out_valid), .out_data(out_data), .done(done)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic [W-1:0] ix, input int n);
        logic [W-1:0] a;
        int nn;
        a = d;
        nn = (n == 0) ? 1 : n;
        for (int j = 0; j < nn; j++) begin
            a = a + ix;
            a = a - W'(j);
            a = a & W'(MASK);
            a = a * W'(K);
        end
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Offer the batch in bd/bi, with gap idle cycles before each word.
    task automatic send(input int n, input int gap);
        for (int b = 0; b < DS; b++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = bd[b];
            in_idx   = bi[b];
            rounds   = RW'(n);
            @(posedge clk);
        end
    endtask

    // Collect and check one batch; poke drives junk while busy.
    task automatic collect(input int n, input bit poke, input string req);
        int cnt;
        int nn;
        nn = (n == 0) ? 1 : n;
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (out_valid || cnt > 5000) break;
            chk(in_ready == 1'b0, "R3", "in_ready while busy", int'(in_ready), 0);
            in_valid = poke;
            in_data  = W'(16'hBEEF + cnt);
            in_idx   = W'(cnt);
            rounds   = poke ? RW'(n + 7) : RW'(n);
        end
        chk(cnt == 4 * nn + 1, "R5", "first-result latency", cnt, 4 * nn + 1);
        for (int b = 0; b < DS; b++) begin
            if (b > 0) @(negedge clk);
            res[b] = out_data;
            chk(out_valid == 1'b1, "R4", "out_valid in burst", int'(out_valid), 1);
            chk(out_data == model(bd[b], bi[b], n), req, "result", int'(out_data), int'(model(bd[b], bi[b], n)));
            chk(in_ready == 1'b0, "R3", "in_ready during results", int'(in_ready), 0);
        end
        @(negedge clk);
        chk(done == 1'b1, "R4", "done after last", int'(done), 1);
        chk(out_valid == 1'b0, "R4", "out_valid with done", int'(out_valid), 0);
        in_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R4", "done one cycle", int'(done), 0);
        chk(in_ready == 1'b1, "R3", "in_ready after done", int'(in_ready), 1);
    endtask

    task automatic run_batch(input int n, input int gap, input bit poke, input string req);
        send(n, gap);
        collect(n, poke, req);
    endtask

    task automatic set_batch(input int d0, input int i0, input int d1, input int i1,
                             input int d2, input int i2, input int d3, input int i3);
        bd[0] = W'(d0); bi[0] = W'(i0);
        bd[1] = W'(d1); bi[1] = W'(i1);
        bd[2] = W'(d2); bi[2] = W'(i2);
        bd[3] = W'(d3); bi[3] = W'(i3);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2, R4, R5: basic batch
    task automatic t_basic();
        set_batch(5, 1, 17, 2, 300, 9, 0, 0);
        run_batch(3, 0, 1'b0, "R2");
        set_batch(16'h1234, 16'h0040, 7, 16'hFFFF, 16'h00FF, 3, 42, 11);
        run_batch(6, 0, 1'b0, "R2");
    endtask

    // R2: additions wrap at the data width
    task automatic t_wrap();
        set_batch(16'hFFF0, 16'h0020, 16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000, 1, 16'hFFFE);
        run_batch(2, 0, 1'b0, "R2");
    endtask

    // R9: round-count edges
    task automatic t_rounds_edges();
        set_batch(9, 4, 10, 5, 11, 6, 12, 7);
        run_batch(1, 0, 1'b0, "R9");
        run_batch(0, 0, 1'b0, "R9");
        set_batch(100, 3, 2000, 8, 3, 13, 65000, 1);
        run_batch(255, 0, 1'b0, "R9");
    endtask

    // R7: idle gaps between accepted words
    task automatic t_gaps();
        set_batch(21, 6, 22, 7, 23, 8, 24, 9);
        run_batch(4, 3, 1'b0, "R7");
    endtask

    // R3, R8: offers and round changes while busy are ignored
    task automatic t_busy();
        set_batch(31, 2, 32, 3, 33, 4, 34, 5);
        run_batch(5, 0, 1'b1, "R8");
        set_batch(41, 10, 42, 11, 43, 12, 44, 13);
        run_batch(2, 0, 1'b0, "R3");
    endtask

    // R6: words do not share state
    task automatic t_indep();
        logic [W-1:0] keep [DS];
        set_batch(100, 1, 100, 2, 200, 3, 300, 4);
        run_batch(7, 0, 1'b0, "R6");
        for (int b = 0; b < DS; b++) keep[b] = res[b];
        bd[2] = W'(999);
        run_batch(7, 0, 1'b0, "R6");
        chk(res[0] == keep[0], "R6", "block0 unchanged", int'(res[0]), int'(keep[0]));
        chk(res[1] == keep[1], "R6", "block1 unchanged", int'(res[1]), int'(keep[1]));
        chk(res[3] == keep[3], "R6", "block3 unchanged", int'(res[3]), int'(keep[3]));
    endtask

    // R10: reset mid-batch aborts it
    task automatic t_midreset();
        int seen;
        set_batch(51, 1, 52, 2, 53, 3, 54, 4);
        send(10, 0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seen = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (out_valid || done || !in_ready) seen++;
        end
        chk(seen == 0, "R10", "activity after abort", seen, 0);
        set_batch(61, 5, 62, 6, 63, 7, 64, 8);
        run_batch(3, 0, 1'b0, "R10");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_wrap();
        t_rounds_edges();
        t_gaps();
        t_busy();
        t_indep();
        t_midreset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule